// File: doc/BRIEF.md
# PSRAM Power-Up Initialization Sequencer

After reset this block walks a serial PSRAM device through a fixed bring-up. It forces the device back to single-line operation and reads the 24-bit identification word. It checks that word for the known-good-die marker and retries the read once if the marker is missing. It then decodes the device capacity, issues a two-step software reset, and finally switches the device into quad command mode. The block does not shift bits itself. Each command goes out as a request on a valid/ready stream to a separate serial engine. That engine reports completion, together with any received bits, on a second valid/ready stream.

A command request carries an opcode, a line-mode flag (0 = single line, 1 = four lines), an address length, a dummy length and a receive length, all counted in bits. The address content is always zero. Once `req_valid` rises, the request stays asserted and keeps every field unchanged until `req_ready` is seen high at a clock edge. The sequencer takes a response only while `rsp_ready` is high, which is only while one request is outstanding. The engine may hold `rsp_valid` high for as long as it needs. Between the accepted response of one command and the next request there is an idle gap of `gap_cycles` cycles, with a minimum of one. This lets the engine raise chip select between commands.

Top module: `psram_init_seq`

## Requirements
- R1: While reset is held, `req_valid`, `rsp_ready`, `done`, `error`, `dev_id` and `cap_code` are all zero.
- R2: The first request is opcode 0xF5 with `req_quad`=1, and with address, dummy and receive lengths of 0.
- R3: An identification read is opcode 0x9F with `req_quad`=0, address length 24, dummy length 0 and receive length 24.
- R4: An ID is good when `rsp_data[15:8]` equals 0x5D. If the first ID is bad, exactly one more identification read follows. If that one is also bad, `error` rises, stays high until reset, and no further request is made.
- R5: The capacity is taken from the extended ID `rsp_data[23:16]` of the good ID. The value 0x26 gives `cap_code` 3. Otherwise bits [7:5] of the extended ID select the code: 0 gives 1 (2 MB), 1 gives 2 (4 MB), 2 gives 3 (8 MB), and any other value gives 0 (unknown). `cap_code` stays 0 when no good ID was seen.
- R6: After a good ID, opcode 0x66 and then opcode 0x99 are requested as two separate single-line commands, with all lengths 0.
- R7: The last request is opcode 0x35, single line, with all lengths 0. Nothing follows it.
- R8: `done` rises in the cycle after the response to the last command is accepted and stays high until reset. `done` and `error` are never high together.
- R9: After each accepted response that is not the last, `req_valid` stays low for exactly max(`gap_cycles`,1) cycles before the next request.
- R10: A pending request holds its opcode and line mode until it is accepted. `rsp_ready` is high only between acceptance of a request and its response, and never in the same cycle as `req_valid`.
- R11: `dev_id` holds the most recent identification word received. Data returned for any other command has no effect on `dev_id` or `cap_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gap_cycles | input | GAP_W | Idle cycles between commands (0 acts as 1) |
| req_valid | output | 1 | Command request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_opcode | output | 8 | Command opcode |
| req_quad | output | 1 | 1 = four-line command, 0 = single line |
| req_addr_bits | output | LEN_W | Address phase length in bits (address value zero) |
| req_dummy_bits | output | LEN_W | Dummy phase length in bits |
| req_rx_bits | output | LEN_W | Receive phase length in bits |
| rsp_valid | input | 1 | Command completed, data valid |
| rsp_ready | output | 1 | Sequencer waits for a completion |
| rsp_data | input | ID_W | Received bits, right-aligned |
| done | output | 1 | Bring-up finished successfully |
| error | output | 1 | Identification failed twice |
| dev_id | output | ID_W | Last identification word received |
| cap_code | output | 2 | Capacity: 0 unknown, 1 2 MB, 2 4 MB, 3 8 MB |

## Verification
If the step counter slips, the stream of opcodes at the request port goes wrong at once. A missed or extra retry shows as a wrong number of 0x9F requests. A skipped step shows as a missing 0x66 or 0x99 one request later. A fault in the gap timer changes the count of idle cycles before the very next request. Capacity or ID capture errors stay hidden until the sequence ends, where `cap_code` and `dev_id` are compared. A late or early `done` is caught in the single cycle after the last response.

// File: rtl/psram_init_pkg.sv
package psram_init_pkg;

  localparam logic [7:0] OP_QUAD_EXIT  = 8'hF5;
  localparam logic [7:0] OP_READ_ID    = 8'h9F;
  localparam logic [7:0] OP_RST_ENABLE = 8'h66;
  localparam logic [7:0] OP_RST_DO     = 8'h99;
  localparam logic [7:0] OP_QUAD_ENTER = 8'h35;
  localparam logic [7:0] GOOD_DIE_MARK = 8'h5D;
  localparam logic [7:0] EXT_SPECIAL   = 8'h26;

  typedef enum logic [2:0] {
    ST_GAP,
    ST_REQ,
    ST_WAIT,
    ST_DONE,
    ST_FAIL
  } seq_state_e;

  typedef enum logic [2:0] {
    STEP_EXIT     = 3'd0,
    STEP_ID       = 3'd1,
    STEP_ID_RETRY = 3'd2,
    STEP_RST_EN   = 3'd3,
    STEP_RST      = 3'd4,
    STEP_ENTER    = 3'd5
  } seq_step_e;

  typedef enum logic [1:0] {
    CAP_UNKNOWN = 2'd0,
    CAP_2MB     = 2'd1,
    CAP_4MB     = 2'd2,
    CAP_8MB     = 2'd3
  } cap_code_e;

endpackage

// File: rtl/psram_cmd_table.sv
module psram_cmd_table
  import psram_init_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int ID_W  = 24
) (
  input  seq_step_e        step,
  output logic [7:0]       opcode,
  output logic             quad,
  output logic [LEN_W-1:0] addr_bits,
  output logic [LEN_W-1:0] dummy_bits,
  output logic [LEN_W-1:0] rx_bits,
  output logic             is_id
);
  localparam logic [LEN_W-1:0] ID_LEN = LEN_W'(ID_W);

  always_comb begin
    opcode     = OP_QUAD_EXIT;
    quad       = 1'b0;
    addr_bits  = '0;
    dummy_bits = '0;
    rx_bits    = '0;
    is_id      = 1'b0;
    case (step)
      STEP_EXIT: begin
        opcode = OP_QUAD_EXIT;
        quad   = 1'b1;
      end
      STEP_ID, STEP_ID_RETRY: begin
        opcode    = OP_READ_ID;
        addr_bits = ID_LEN;
        rx_bits   = ID_LEN;
        is_id     = 1'b1;
      end
      STEP_RST_EN: opcode = OP_RST_ENABLE;
      STEP_RST:    opcode = OP_RST_DO;
      STEP_ENTER:  opcode = OP_QUAD_ENTER;
      default:     opcode = OP_QUAD_EXIT;
    endcase
  end
endmodule

// File: rtl/psram_id_decode.sv
module psram_id_decode
  import psram_init_pkg::*;
#(
  parameter int ID_W = 24
) (
  input  logic [ID_W-1:0] id_word,
  output logic            id_good,
  output cap_code_e       cap
);
  localparam int MARK_LSB = 8;
  localparam int EXT_LSB  = 16;
  localparam int SIZE_LSB = 5;

  logic [7:0] mark_byte;
  logic [7:0] ext_byte;
  logic [2:0] size_field;

  assign mark_byte  = id_word[MARK_LSB +: 8];
  assign ext_byte   = id_word[EXT_LSB +: 8];
  assign size_field = ext_byte[SIZE_LSB +: 3];
  assign id_good    = (mark_byte == GOOD_DIE_MARK);

  always_comb begin
    if (ext_byte == EXT_SPECIAL) begin
      cap = CAP_8MB;
    end else begin
      case (size_field)
        3'd0:    cap = CAP_2MB;
        3'd1:    cap = CAP_4MB;
        3'd2:    cap = CAP_8MB;
        default: cap = CAP_UNKNOWN;
      endcase
    end
  end
endmodule

// File: rtl/psram_gap_timer.sv
module psram_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [GAP_W-1:0] gap_len,
  output logic             expired
);
  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W:0]   eff_len;

  assign eff_len = (gap_len == '0) ? (GAP_W+1)'(1) : {1'b0, gap_len};
  assign expired = run && (({1'b0, cnt_q} + (GAP_W+1)'(1)) >= eff_len);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || expired) cnt_q <= '0;
    else                           cnt_q <= cnt_q + GAP_W'(1);
  end
endmodule

// File: rtl/psram_init_seq.sv
module psram_init_seq
  import psram_init_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int ID_W  = 24,
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap_cycles,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [7:0]       req_opcode,
  output logic             req_quad,
  output logic [LEN_W-1:0] req_addr_bits,
  output logic [LEN_W-1:0] req_dummy_bits,
  output logic [LEN_W-1:0] req_rx_bits,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [ID_W-1:0]  rsp_data,
  output logic             done,
  output logic             error,
  output logic [ID_W-1:0]  dev_id,
  output logic [1:0]       cap_code
);
  seq_state_e state_q, state_d;
  seq_step_e  step_q, step_d;
  logic       gap_expired;
  logic       step_is_id;
  logic       id_good;
  cap_code_e  id_cap;
  logic       rsp_take;
  logic [ID_W-1:0] dev_id_q;
  cap_code_e  cap_q;

  psram_cmd_table #(.LEN_W(LEN_W), .ID_W(ID_W)) table_i (
    .step       (step_q),
    .opcode     (req_opcode),
    .quad       (req_quad),
    .addr_bits  (req_addr_bits),
    .dummy_bits (req_dummy_bits),
    .rx_bits    (req_rx_bits),
    .is_id      (step_is_id)
  );

  psram_id_decode #(.ID_W(ID_W)) decode_i (
    .id_word (rsp_data),
    .id_good (id_good),
    .cap     (id_cap)
  );

  psram_gap_timer #(.GAP_W(GAP_W)) gap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == ST_GAP),
    .gap_len (gap_cycles),
    .expired (gap_expired)
  );

  assign req_valid = (state_q == ST_REQ);
  assign rsp_ready = (state_q == ST_WAIT);
  assign rsp_take  = rsp_ready && rsp_valid;
  assign done      = (state_q == ST_DONE);
  assign error     = (state_q == ST_FAIL);
  assign dev_id    = dev_id_q;
  assign cap_code  = cap_q;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      ST_GAP: if (gap_expired) state_d = ST_REQ;
      ST_REQ: if (req_ready)   state_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_take) begin
          if (step_is_id) begin
            if (id_good) begin
              step_d  = STEP_RST_EN;
              state_d = ST_GAP;
            end else if (step_q == STEP_ID) begin
              step_d  = STEP_ID_RETRY;
              state_d = ST_GAP;
            end else begin
              state_d = ST_FAIL;
            end
          end else if (step_q == STEP_ENTER) begin
            state_d = ST_DONE;
          end else begin
            step_d  = seq_step_e'(step_q + 3'd1);
            state_d = ST_GAP;
          end
        end
      end
      ST_DONE: state_d = ST_DONE;
      ST_FAIL: state_d = ST_FAIL;
      default: state_d = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_GAP;
      step_q   <= STEP_EXIT;
      dev_id_q <= '0;
      cap_q    <= CAP_UNKNOWN;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (rsp_take && step_is_id) begin
        dev_id_q <= rsp_data;
        if (id_good) cap_q <= id_cap;
      end
    end
  end
endmodule

// File: rtl/psram_init_seq_chk.sv
module psram_init_seq_chk #(
  parameter int LEN_W = 6,
  parameter int ID_W  = 24,
  parameter int GAP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [GAP_W-1:0] gap_cycles,
  input logic             req_valid,
  input logic             req_ready,
  input logic [7:0]       req_opcode,
  input logic             req_quad,
  input logic [LEN_W-1:0] req_addr_bits,
  input logic [LEN_W-1:0] req_dummy_bits,
  input logic [LEN_W-1:0] req_rx_bits,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [ID_W-1:0]  rsp_data,
  input logic             done,
  input logic             error,
  input logic [ID_W-1:0]  dev_id,
  input logic [1:0]       cap_code
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_opcode) && $stable(req_quad));

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  assert_done_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rsp_valid && rsp_ready));

  assert_err_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error && !req_valid);

  assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(cap_code) && $stable(dev_id));

  assert_min_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rsp_ready) |-> !req_valid);
endmodule

bind psram_init_seq psram_init_seq_chk #(.LEN_W(LEN_W), .ID_W(ID_W), .GAP_W(GAP_W)) chk_i (.*);

// File: tb/psram_init_seq_tb.sv
module psram_init_seq_tb_top;
  localparam int LEN_W = 6;
  localparam int ID_W  = 24;
  localparam int GAP_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [GAP_W-1:0] gap_cycles = '0;
  logic             req_valid;
  logic             req_ready = 1'b0;
  logic [7:0]       req_opcode;
  logic             req_quad;
  logic [LEN_W-1:0] req_addr_bits, req_dummy_bits, req_rx_bits;
  logic             rsp_valid = 1'b0;
  logic             rsp_ready;
  logic [ID_W-1:0]  rsp_data = '0;
  logic             done, error;
  logic [ID_W-1:0]  dev_id;
  logic [1:0]       cap_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] exp_op [0:7];
  logic       exp_q  [0:7];
  int         exp_len[0:7];
  int         exp_n;

  psram_init_seq #(.LEN_W(LEN_W), .ID_W(ID_W), .GAP_W(GAP_W)) dut_i (.*);

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic bit good_id(input logic [23:0] id);
    return id[15:8] == 8'h5D;
  endfunction

  function automatic logic [1:0] exp_cap(input logic [23:0] id);
    if (id[23:16] == 8'h26) return 2'd3;
    case (id[23:21])
      3'd0: return 2'd1;
      3'd1: return 2'd2;
      3'd2: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic push(input logic [7:0] op, input logic q, input int len);
    exp_op[exp_n] = op; exp_q[exp_n] = q; exp_len[exp_n] = len; exp_n++;
  endtask

  task automatic run_case(input int gap, input logic [23:0] id1, input logic [23:0] id2);
    int n = 0;
    int id_cnt = 0;
    bit ok1 = good_id(id1);
    bit ok2 = good_id(id2);
    bit success = ok1 || ok2;
    logic [23:0] fin_id = ok1 ? id1 : id2;
    logic [7:0] got_op [0:7];
    logic       got_q  [0:7];
    int         got_a  [0:7];
    int         got_d  [0:7];
    int         got_r  [0:7];
    exp_n = 0;
    push(8'hF5, 1'b1, 0);
    push(8'h9F, 1'b0, 24);
    if (!ok1) push(8'h9F, 1'b0, 24);
    if (success) begin
      push(8'h66, 1'b0, 0);
      push(8'h99, 1'b0, 0);
      push(8'h35, 1'b0, 0);
    end
    rst_n = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0;
    gap_cycles = GAP_W'(gap);
    repeat (3) @(negedge clk);
    check(!req_valid && !rsp_ready && !done && !error && dev_id == 0 && cap_code == 0,
          "R1 reset state", {req_valid, rsp_ready, done, error, cap_code}, 0);
    rst_n = 1'b1;
    while (n < 8) begin
      int gcnt = 0;
      while (!req_valid && !done && !error) begin
        gcnt++;
        @(negedge clk);
      end
      if (done || error) break;
      if (n > 0) begin
        int eg = (gap == 0) ? 1 : gap;
        check(gcnt == eg, "R9 idle gap", gcnt, eg);
      end
      got_op[n] = req_opcode; got_q[n] = req_quad;
      got_a[n] = req_addr_bits; got_d[n] = req_dummy_bits; got_r[n] = req_rx_bits;
      repeat ($urandom % 3) begin
        @(negedge clk);
        check(req_valid && req_opcode == got_op[n], "R10 request held", req_opcode, got_op[n]);
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      check(rsp_ready && !req_valid, "R10 waiting for response", {rsp_ready, req_valid}, 2'b10);
      repeat ($urandom % 4) @(negedge clk);
      if (got_op[n] == 8'h9F) begin
        rsp_data = (id_cnt == 0) ? id1 : id2;
        id_cnt++;
      end else begin
        rsp_data = 24'($urandom);
      end
      rsp_valid = 1'b1;
      check(!done, "R8 done not early", done, 0);
      @(negedge clk);
      rsp_valid = 1'b0;
      n++;
      if (success && n == exp_n)
        check(done, "R8 done one cycle after last response", done, 1);
    end
    check(n == exp_n, "R4 command count", n, exp_n);
    for (int i = 0; i < exp_n && i < n; i++) begin
      string tag;
      case (exp_op[i])
        8'hF5: tag = "R2 quad exit";
        8'h9F: tag = "R3 id read";
        8'h35: tag = "R7 quad enter";
        default: tag = "R6 reset pair";
      endcase
      check(got_op[i] == exp_op[i] && got_q[i] == exp_q[i], tag,
            {got_op[i], got_q[i]}, {exp_op[i], exp_q[i]});
      check(got_a[i] == exp_len[i] && got_r[i] == exp_len[i] && got_d[i] == 0, tag,
            {got_a[i], got_r[i], got_d[i]}, {exp_len[i], exp_len[i], 0});
    end
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!req_valid, "R7 nothing after end", req_valid, 0);
    end
    check(done == success && error == !success, "R8 end flags",
          {done, error}, {success, !success});
    check(dev_id == fin_id, "R11 last id held", dev_id, fin_id);
    check(cap_code == (success ? exp_cap(fin_id) : 2'd0), "R5 capacity",
          cap_code, success ? exp_cap(fin_id) : 2'd0);
  endtask

  function automatic logic [23:0] rand_id();
    logic [7:0] ext;
    logic [7:0] mark;
    ext  = ($urandom % 4 == 0) ? 8'h26 : 8'($urandom);
    mark = ($urandom % 3 == 0) ? 8'($urandom) : 8'h5D;
    return {ext, mark, 8'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    run_case(0, 24'h005D11, 24'h000000);
    run_case(3, 24'h2612AB, 24'h000000);
    run_case(1, 24'h40A000, 24'h205D7E);
    run_case(2, 24'h40A000, 24'h11EE00);
    run_case(5, 24'h605D00, 24'h000000);
    run_case(4, 24'hE05D00, 24'h000000);
    for (int c = 0; c < 40; c++) run_case($urandom % 6, rand_id(), rand_id());
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule